// File: doc/BRIEF.md
# Bus-to-Network Channel Register Wrapper

This block sits between a simple single-cycle memory-mapped bus and a set of network channels. Each channel has an outgoing FIFO that the network drains and an incoming FIFO that the network fills. Software sees a status word with flow-control flags for every channel. It also sees one data window per channel: a write to the window pushes a word outward, and a read from it pops a word from the incoming side.

The bus never waits. A remote read is therefore posted. Software loads a remote address and then writes a go word that carries the word count and the channel. The wrapper pushes one header word onto that channel's outgoing FIFO and remembers how many words it expects back. When enough words have arrived, a sticky read-done bit is set. Words that arrive while no request is outstanding count as messages and set a message bit. Both bits, plus underflow and overflow error bits, can drive an interrupt through an enable mask. A polling mode holds the interrupt low, and software then relies on the status and pending words instead.

Top module: `chan_bridge_regs`

## Requirements
- R1: After reset the status word reads, per channel, out-room=1 and in-near-empty=1 with all other flags 0 (0x99 for two channels). Pending reads 0, `irq` is 0, `net_tx_valid` is 0 and `net_rx_ready` is all ones.
- R2: The status word (address 0) holds a 4-bit group per channel c at bits [4c+3:4c]. Bit 0 means the outgoing FIFO is not full. Bit 1 means its free slots are at most AF_SLACK. Bit 2 means the incoming FIFO is not empty. Bit 3 means its fill level is at most AE_SLACK.
- R3: A write to data window 8+c pushes the write data onto outgoing FIFO c. Words leave on lane c of `net_tx_data`, oldest first, one per cycle in which valid and ready are both high.
- R4: A read of window 8+c returns the head of incoming FIFO c in the same cycle and removes it. The network pushes on lane c while `net_rx_valid[c]` and `net_rx_ready[c]` are both high, and `net_rx_ready[c]` is high exactly when that FIFO is not full.
- R5: A write to address 4 loads the remote address. A write to address 5 with a count in bits [5:0] and the channel in the bits above it pushes the header {2'b01, count[5:0], address[23:0]} onto that channel's outgoing FIFO. The bus access completes in that cycle.
- R6: While a request is outstanding, arriving words do not set the message bit. Once the incoming fill level reaches the count, pending bit 0 of that channel's group (read done) is set and the request ends.
- R7: A word accepted on an incoming channel with no outstanding request sets pending bit 1 of that channel's group (message).
- R8: A read of an empty window returns 0 and sets pending bit 2 (underflow). A push onto a full outgoing FIFO, from the window or from a request, is dropped and sets pending bit 3 (overflow).
- R9: The pending word (address 2) is cleared by writing 1s. If a clear and a new event hit the same bit in one cycle, the bit stays set.
- R10: `irq` is the OR of the pending bits ANDed with the enable word (address 3, same layout), while the control bit at address 1 bit 0 is 0. With that bit at 1 (polling), `irq` stays low and the pending bits keep updating.
- R11: A go write with count 0 is ignored: no header is pushed and no request starts.
- R12: AF_SLACK and AE_SLACK are parameters, both 1 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the cycle of the access |
| irq | output | 1 | Interrupt to the local master |
| net_tx_valid | output | NCH | Outgoing word available, per channel |
| net_tx_data | output | NCH*DW | Outgoing word, lane c at bits [DW*c+DW-1:DW*c] |
| net_tx_ready | input | NCH | Network takes the outgoing word |
| net_rx_valid | input | NCH | Incoming word offered, per channel |
| net_rx_data | input | NCH*DW | Incoming word, one lane per channel |
| net_rx_ready | output | NCH | Incoming FIFO can accept a word |

## Verification
Two functions can land on one pending bit in the same cycle: a software write-1 clear of the message bit, and the arrival of a new network word that sets that bit again. The bench drives the clearing bus write and the network push in the same clock cycle. It expects the bit still set afterwards, and then expects a plain clear to zero it. A second overlap sits at the request boundary: the word that completes a posted read must set read done and must not set the message bit, while the next word after it must set the message bit.

// File: rtl/chb_pkg.sv
package chb_pkg;
   // register word addresses
   localparam int unsigned REG_STATUS = 0;
   localparam int unsigned REG_CTRL   = 1;
   localparam int unsigned REG_PEND   = 2;
   localparam int unsigned REG_IEN    = 3;
   localparam int unsigned REG_RADDR  = 4;
   localparam int unsigned REG_RGO    = 5;

   localparam int unsigned FLAGS_PER_CH = 4;

   // status flag positions within a channel group
   localparam int unsigned ST_TX_ROOM      = 0;
   localparam int unsigned ST_TX_NEARFULL  = 1;
   localparam int unsigned ST_RX_AVAIL     = 2;
   localparam int unsigned ST_RX_NEAREMPTY = 3;

   // pending cause positions within a channel group
   localparam int unsigned PD_RDDONE = 0;
   localparam int unsigned PD_MSG    = 1;
   localparam int unsigned PD_UNF    = 2;
   localparam int unsigned PD_OVF    = 3;

   localparam logic [1:0] HDR_READ = 2'b01;
   localparam int unsigned HDR_TYPE_W = 2;
endpackage

// File: rtl/chb_fifo.sv
module chb_fifo #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 4,
   parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          full,
   output logic          empty,
   output logic [LW-1:0] level
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2 = (DEPTH == (1 << PW));

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;
   logic [LW-1:0] cnt;
   logic          push_ok, pop_ok;

   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;

   generate
      if (POW2) begin : g_wrap_nat
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp_nx;
         if (pop_ok)  rp <= rp_nx;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= din;
   end

   assign full  = (cnt == LW'(DEPTH));
   assign empty = (cnt == '0);
   assign level = cnt;
   assign dout  = empty ? '0 : mem[rp];

   // R8
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> $stable(level));
endmodule

// File: rtl/chb_chan.sv
module chb_chan
   import chb_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned DEPTH    = 4,
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned AF_SLACK = 1,
   parameter int unsigned AE_SLACK = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tx_push,
   input  logic [DW-1:0]           tx_din,
   output logic                    net_tx_valid,
   output logic [DW-1:0]           net_tx_data,
   input  logic                    net_tx_ready,
   input  logic                    rx_pop,
   output logic [DW-1:0]           rx_dout,
   input  logic                    net_rx_valid,
   input  logic [DW-1:0]           net_rx_data,
   output logic                    net_rx_ready,
   input  logic                    req_start,
   input  logic [CNT_W-1:0]        req_cnt,
   input  logic [FLAGS_PER_CH-1:0] pend_clr,
   output logic [FLAGS_PER_CH-1:0] pend,
   output logic [FLAGS_PER_CH-1:0] status
);
   localparam int unsigned LW = $clog2(DEPTH + 1);

   logic          tx_full, tx_empty, rx_full, rx_empty;
   logic [LW-1:0] tx_lvl, rx_lvl;
   logic          rx_acc, busy, done_hit;
   logic [CNT_W-1:0]        need;
   logic [FLAGS_PER_CH-1:0] pend_q, set_v;

   chb_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .din(tx_din),
      .pop(net_tx_ready), .dout(net_tx_data),
      .full(tx_full), .empty(tx_empty), .level(tx_lvl));

   chb_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .push(net_rx_valid), .din(net_rx_data),
      .pop(rx_pop), .dout(rx_dout),
      .full(rx_full), .empty(rx_empty), .level(rx_lvl));

   assign net_tx_valid = !tx_empty;
   assign net_rx_ready = !rx_full;
   assign rx_acc       = net_rx_valid && !rx_full;
   assign done_hit     = busy && (32'(rx_lvl) >= 32'(need));

   always_comb begin
      set_v            = '0;
      set_v[PD_RDDONE] = done_hit;
      set_v[PD_MSG]    = rx_acc && !busy;
      set_v[PD_UNF]    = rx_pop && rx_empty;
      set_v[PD_OVF]    = tx_push && tx_full;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         busy   <= 1'b0;
         need   <= '0;
      end else begin
         pend_q <= (pend_q & ~pend_clr) | set_v;
         if (req_start && !tx_full) begin
            busy <= 1'b1;
            need <= req_cnt;
         end else if (done_hit) begin
            busy <= 1'b0;
         end
      end
   end

   assign pend = pend_q;

   always_comb begin
      status                  = '0;
      status[ST_TX_ROOM]      = !tx_full;
      status[ST_TX_NEARFULL]  = (32'(DEPTH) - 32'(tx_lvl)) <= AF_SLACK;
      status[ST_RX_AVAIL]     = !rx_empty;
      status[ST_RX_NEAREMPTY] = 32'(rx_lvl) <= AE_SLACK;
   end

   // R8
   ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push && tx_full) |=> pend_q[PD_OVF]);
   // R8
   unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && rx_empty) |-> (rx_dout == '0));
   // R7
   msg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (net_rx_valid && net_rx_ready && !busy) |=> pend_q[PD_MSG]);
   // R6
   rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (32'(rx_lvl) >= 32'(need)) && !req_start) |=> (pend_q[PD_RDDONE] && !busy));
endmodule

// File: rtl/chan_bridge_regs.sv
module chan_bridge_regs
   import chb_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned NCH      = 2,
   parameter int unsigned DEPTH    = 4,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned AF_SLACK = 1,
   parameter int unsigned AE_SLACK = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              irq,
   output logic [NCH-1:0]    net_tx_valid,
   output logic [NCH*DW-1:0] net_tx_data,
   input  logic [NCH-1:0]    net_tx_ready,
   input  logic [NCH-1:0]    net_rx_valid,
   input  logic [NCH*DW-1:0] net_rx_data,
   output logic [NCH-1:0]    net_rx_ready
);
   localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int unsigned RA_W  = DW - HDR_TYPE_W - CNT_W;
   localparam int unsigned IW    = ADDR_W - 1;
   localparam int unsigned FL_W  = NCH * FLAGS_PER_CH;

   generate
      if (DEPTH < 2)                   begin : g_e0 $error("DEPTH must be at least 2"); end
      if (FL_W > DW)                   begin : g_e1 $error("flag words exceed DW"); end
      if (ADDR_W < 4)                  begin : g_e2 $error("ADDR_W must be at least 4"); end
      if (NCH > (1 << IW))             begin : g_e3 $error("too many channels for ADDR_W"); end
      if (CNT_W + CH_W > DW)           begin : g_e4 $error("go word fields exceed DW"); end
      if (RA_W < 1)                    begin : g_e5 $error("no room for remote address"); end
      if (AF_SLACK >= DEPTH)           begin : g_e6 $error("AF_SLACK too large"); end
      if (AE_SLACK >= DEPTH)           begin : g_e7 $error("AE_SLACK too large"); end
   endgenerate

   logic            wr_acc, rd_acc, win_hit, go_ok, poll_q;
   logic [31:0]     addr32;
   logic [IW-1:0]   win_idx;
   logic [CH_W-1:0] go_ch;
   logic [CNT_W-1:0] go_cnt;
   logic [RA_W-1:0] raddr_q;
   logic [FL_W-1:0] ien_q, pend_all, stat_all;
   logic [DW-1:0]   header, win_rd;
   logic [DW-1:0]   rx_dout [NCH];

   assign wr_acc  = bus_sel && bus_wr;
   assign rd_acc  = bus_sel && !bus_wr;
   assign addr32  = 32'(bus_addr);
   assign win_idx = bus_addr[IW-1:0];
   assign win_hit = bus_addr[ADDR_W-1] && (32'(win_idx) < NCH);
   assign go_cnt  = bus_wdata[CNT_W-1:0];
   assign go_ch   = bus_wdata[CNT_W +: CH_W];
   assign go_ok   = wr_acc && (addr32 == REG_RGO) && (go_cnt != '0) && (32'(go_ch) < NCH);
   assign header  = {HDR_READ, go_cnt, raddr_q};

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic win_sel, req_here;
         assign win_sel  = win_hit && (32'(win_idx) == c);
         assign req_here = go_ok && (32'(go_ch) == c);

         chb_chan #(
            .DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W),
            .AF_SLACK(AF_SLACK), .AE_SLACK(AE_SLACK)
         ) u_ch (
            .clk(clk), .rst_n(rst_n),
            .tx_push((wr_acc && win_sel) || req_here),
            .tx_din(req_here ? header : bus_wdata),
            .net_tx_valid(net_tx_valid[c]),
            .net_tx_data(net_tx_data[DW*c +: DW]),
            .net_tx_ready(net_tx_ready[c]),
            .rx_pop(rd_acc && win_sel),
            .rx_dout(rx_dout[c]),
            .net_rx_valid(net_rx_valid[c]),
            .net_rx_data(net_rx_data[DW*c +: DW]),
            .net_rx_ready(net_rx_ready[c]),
            .req_start(req_here),
            .req_cnt(go_cnt),
            .pend_clr((wr_acc && addr32 == REG_PEND) ?
                      bus_wdata[FLAGS_PER_CH*c +: FLAGS_PER_CH] : '0),
            .pend(pend_all[FLAGS_PER_CH*c +: FLAGS_PER_CH]),
            .status(stat_all[FLAGS_PER_CH*c +: FLAGS_PER_CH]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         poll_q  <= 1'b0;
         ien_q   <= '0;
         raddr_q <= '0;
      end else if (wr_acc) begin
         if (addr32 == REG_CTRL)  poll_q  <= bus_wdata[0];
         if (addr32 == REG_IEN)   ien_q   <= bus_wdata[FL_W-1:0];
         if (addr32 == REG_RADDR) raddr_q <= bus_wdata[RA_W-1:0];
      end
   end

   always_comb begin
      win_rd = '0;
      for (int c = 0; c < NCH; c++)
         if (32'(win_idx) == c) win_rd = rx_dout[c];
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_acc) begin
         if (win_hit)                      bus_rdata = win_rd;
         else if (addr32 == REG_STATUS)    bus_rdata = DW'(stat_all);
         else if (addr32 == REG_CTRL)      bus_rdata = DW'(poll_q);
         else if (addr32 == REG_PEND)      bus_rdata = DW'(pend_all);
         else if (addr32 == REG_IEN)       bus_rdata = DW'(ien_q);
         else if (addr32 == REG_RADDR)     bus_rdata = DW'(raddr_q);
      end
   end

   assign irq = !poll_q && |(pend_all & ien_q);

   // R10
   poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && addr32 == REG_CTRL && bus_wdata[0]) |=> !irq);
endmodule

// File: tb/sim_chan_bridge_regs.sv
module sim_chan_bridge_regs;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic        irq;
   logic [1:0]  txv, txr = '0, rxv = '0, rxr;
   logic [63:0] txd, rxd = '0;
   int n_chk = 0, n_err = 0;
   bit finished = 1'b0;

   chan_bridge_regs u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq),
      .net_tx_valid(txv), .net_tx_data(txd), .net_tx_ready(txr),
      .net_rx_valid(rxv), .net_rx_data(rxd), .net_rx_ready(rxr));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
      @(negedge clk); sel = 0; wr = 0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); sel = 1; wr = 0; addr = a;
      #1 d = rdata;
      @(negedge clk); sel = 0;
   endtask

   task automatic read_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] v;
      bus_read(a, v);
      chk(tag, v, exp);
   endtask

   task automatic tx_take(input int c, input logic [31:0] exp, input string tag);
      @(negedge clk);
      chk({tag, " valid"}, 32'(txv[c]), 32'd1);
      chk({tag, " data"}, txd[32*c +: 32], exp);
      txr[c] = 1'b1;
      @(negedge clk); txr[c] = 1'b0;
   endtask

   task automatic rx_put(input int c, input logic [31:0] d);
      @(negedge clk); rxv[c] = 1'b1; rxd[32*c +: 32] = d;
      @(negedge clk); rxv[c] = 1'b0;
   endtask

   task automatic t_reset;
      read_chk(4'd0, 32'h99, "R1 status");
      read_chk(4'd2, 32'h0, "R1 pend");
      chk("R1 irq", 32'(irq), 32'd0);
      chk("R1 tx valid", 32'(txv), 32'd0);
      chk("R1 rx ready", 32'(rxr), 32'd3);
   endtask

   task automatic t_tx_path;
      bus_write(4'd8, 32'h11); bus_write(4'd8, 32'h22); bus_write(4'd8, 32'h33);
      read_chk(4'd0, 32'h9B, "R2 R12 near full");
      bus_write(4'd8, 32'h44);
      read_chk(4'd0, 32'h9A, "R2 full");
      bus_write(4'd8, 32'h55);
      read_chk(4'd2, 32'h08, "R8 overflow");
      tx_take(0, 32'h11, "R3 w0"); tx_take(0, 32'h22, "R3 w1");
      tx_take(0, 32'h33, "R3 w2"); tx_take(0, 32'h44, "R3 w3");
      chk("R8 dropped word", 32'(txv[0]), 32'd0);
      bus_write(4'd9, 32'h77);
      tx_take(1, 32'h77, "R3 lane1");
      bus_write(4'd2, 32'h08);
      read_chk(4'd2, 32'h0, "R9 clear");
   endtask

   task automatic t_rx_msg;
      rx_put(0, 32'hA5);
      read_chk(4'd2, 32'h02, "R7 msg");
      read_chk(4'd0, 32'h9D, "R2 R12 near empty");
      rx_put(0, 32'h5A);
      read_chk(4'd0, 32'h95, "R2 two words");
      read_chk(4'd8, 32'hA5, "R4 head0");
      read_chk(4'd8, 32'h5A, "R4 head1");
      read_chk(4'd8, 32'h0, "R8 empty read");
      read_chk(4'd2, 32'h06, "R8 underflow");
      bus_write(4'd2, 32'h06);
      read_chk(4'd2, 32'h0, "R9 clear");
   endtask

   task automatic t_irq;
      bus_write(4'd3, 32'h02);
      rx_put(1, 32'hC1);
      chk("R10 masked", 32'(irq), 32'd0);
      rx_put(0, 32'hC0);
      chk("R10 enabled", 32'(irq), 32'd1);
      bus_write(4'd1, 32'h1);
      chk("R10 poll low", 32'(irq), 32'd0);
      rx_put(0, 32'hC2);
      read_chk(4'd2, 32'h22, "R10 pend in poll");
      bus_write(4'd1, 32'h0);
      chk("R10 poll off", 32'(irq), 32'd1);
      bus_write(4'd2, 32'h22);
      chk("R10 cleared", 32'(irq), 32'd0);
      read_chk(4'd8, 32'hC0, "R4 drain0");
      read_chk(4'd8, 32'hC2, "R4 drain1");
      read_chk(4'd9, 32'hC1, "R4 drain2");
      bus_write(4'd3, 32'h0);
   endtask

   task automatic t_rreq;
      bus_write(4'd4, 32'h00123456);
      bus_write(4'd5, 32'h43);
      tx_take(1, 32'h43123456, "R5 header");
      bus_write(4'd5, 32'h40);
      @(negedge clk);
      chk("R11 zero count", 32'(txv[1]), 32'd0);
      rx_put(1, 32'hD0); rx_put(1, 32'hD1);
      read_chk(4'd2, 32'h0, "R6 no msg while waiting");
      rx_put(1, 32'hD2);
      @(negedge clk);
      read_chk(4'd2, 32'h10, "R6 read done");
      bus_write(4'd2, 32'h10);
      rx_put(1, 32'hD3);
      read_chk(4'd2, 32'h20, "R7 msg after request");
      bus_write(4'd2, 32'h20);
      read_chk(4'd9, 32'hD0, "R6 data0"); read_chk(4'd9, 32'hD1, "R6 data1");
      read_chk(4'd9, 32'hD2, "R6 data2"); read_chk(4'd9, 32'hD3, "R4 data3");
   endtask

   task automatic t_same_cycle;
      rx_put(0, 32'hE0);
      read_chk(4'd2, 32'h02, "R7 first");
      @(negedge clk);
      sel = 1; wr = 1; addr = 4'd2; wdata = 32'h02;
      rxv[0] = 1'b1; rxd[31:0] = 32'hE1;
      @(negedge clk);
      sel = 0; wr = 0; rxv[0] = 1'b0;
      read_chk(4'd2, 32'h02, "R9 set wins");
      bus_write(4'd2, 32'h02);
      read_chk(4'd2, 32'h0, "R9 plain clear");
      read_chk(4'd8, 32'hE0, "R4 e0");
      read_chk(4'd8, 32'hE1, "R4 e1");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_tx_path();
      t_rx_msg();
      t_irq();
      t_rreq();
      t_same_cycle();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule